// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This unit adds or subtracts two 32-bit binary floating-point words. Each word has a sign bit at position 31, an 8-bit exponent at 30:23 stored with a bias of 127, and a 23-bit fraction at 22:0. A normal value carries a hidden leading 1 above the fraction. When `op_sub` is high, the sign of the second operand is inverted and the two values are added. The operand with the smaller magnitude is shifted right until its exponent matches the larger one. Bits that fall off the right end are kept as guard, round and sticky bits. The unit then adds or subtracts the significands, normalizes the sum in either direction, rounds to nearest-even and packs the result.

The datapath has two register stages: one after unpacking and alignment, and one on the outputs. A new operation can enter on every clock. Subnormal inputs are read as signed zero. Results too small for the normal range are flushed to signed zero and raise the underflow flag. Results too large become infinity and raise the overflow flag. NaN inputs and opposing infinities give a single quiet NaN and raise the invalid flag. Every flag only describes the operation shown on the same cycle. Nothing traps.

Top module: `fp_addsub`

## Requirements
- R1: For two finite normal operands, `result` is the correctly rounded sum, with no flag raised when the sum lies in the normal range (for example 0x3F800000 + 0x40000000 = 0x40400000).
- R2: With `op_sub`=1 the result equals opnd_a plus opnd_b with bit 31 of opnd_b inverted (0x3F800000 - 0x40400000 = 0xC0000000).
- R3: The smaller operand is aligned to the larger exponent. Shifted-out bits round to nearest, with ties going to the even fraction: 0x3F800000+0x33800000 = 0x3F800000, 0x3F800001+0x33800000 = 0x3F800002, 0x3F800000+0x33800001 = 0x3F800001.
- R4: A carry out of the significand sum shifts the result right by one and increments the exponent (0x3FC00000 + 0x3FC00000 = 0x40400000).
- R5: After cancellation, leading zeros are removed by a left shift, and the exponent drops by one per position (0x3F800000 - 0x3F7FFFFF = 0x33800000).
- R6: An exact zero from operands of opposite effective sign is +0 (0x00000000). The sum of two zeros is -0 (0x80000000) only when both effective signs are negative.
- R7: A rounded exponent of 255 or more sets `flag_ovf` and gives infinity with the result sign: exponent field all ones, fraction zero.
- R8: A normalized exponent of 0 or below sets `flag_unf` and gives signed zero with the result sign.
- R9: An input with exponent field 0 is read as signed zero whatever its fraction, and raises no flag by itself.
- R10: A NaN input (exponent field 255, fraction nonzero), or the sum of infinities whose effective signs differ, gives 0x7FC00000 and sets `flag_inv`. At most one flag is high at a time, and no NaN pattern appears without `flag_inv`.
- R11: When exactly one operand is infinite, or both are with the same effective sign, the result is that signed infinity with no flag.
- R12: Each accepted operation appears on the outputs, with `out_valid` high, exactly two clock edges after `in_valid` is sampled high. Back-to-back inputs give back-to-back results in order.
- R13: While `rst` is high, the outputs are driven low at each clock edge: `out_valid`, `result` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sub | input | 1 | 1 selects a minus b, 0 selects a plus b |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Packed result |
| flag_ovf | output | 1 | Exponent overflow, result is infinity |
| flag_unf | output | 1 | Exponent underflow, result flushed to zero |
| flag_inv | output | 1 | Invalid operation, result is quiet NaN |

## Verification
The hardest case to reach from the ports is a round-up whose carry ripples through every fraction bit and pushes the exponent past its maximum. It needs the largest finite value plus an addend sitting exactly at half an ulp of it. The stimulus adds 0x7F7FFFFF and 0x73000000. That places only the guard bit, so the tie-to-even rule on an odd fraction has to turn a finite sum into infinity. Exact ties and the deepest cancellation (a difference of one ulp between neighbouring values near the normal minimum) are built the same way, from exponent gaps of 24 and 0.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;
  // guard, round, sticky
  localparam int GRS_W      = 3;

  typedef struct packed {
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } fp_class_t;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpa_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  input  logic                  flip_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       sig_o,
  output fp_class_t             cls_o
);
  logic [FRAC_W-1:0] frac;
  logic              exp_max;
  logic              exp_min;

  always_comb begin
    frac          = word_i[FRAC_W-1:0];
    exp_o         = word_i[EXP_W+FRAC_W-1:FRAC_W];
    sign_o        = word_i[EXP_W+FRAC_W] ^ flip_i;
    exp_max       = &exp_o;
    exp_min       = ~|exp_o;
    // subnormals collapse onto signed zero
    cls_o.is_zero = exp_min;
    cls_o.is_inf  = exp_max & ~|frac;
    cls_o.is_nan  = exp_max & |frac;
    sig_o         = exp_min ? '0 : {1'b1, frac};
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                      sa_i,
  input  logic [EXP_W-1:0]          ea_i,
  input  logic [FRAC_W:0]           siga_i,
  input  logic                      sb_i,
  input  logic [EXP_W-1:0]          eb_i,
  input  logic [FRAC_W:0]           sigb_i,
  output logic                      sign_o,
  output logic [EXP_W-1:0]          exp_o,
  output logic [FRAC_W+GRS_W:0]     big_o,
  output logic [FRAC_W+GRS_W:0]     small_o,
  output logic                      eff_sub_o
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + GRS_W;

  logic             a_big;
  logic [EXP_W-1:0] e_small;
  logic [EXP_W-1:0] diff;
  logic [SIG_W-1:0] sig_big;
  logic [SIG_W-1:0] sig_small;
  logic [EXT_W-1:0] ext_s;
  logic [EXT_W-1:0] shifted;
  logic             sticky;

  always_comb begin
    // magnitude compare: exponent first, then significand
    a_big     = {ea_i, siga_i} >= {eb_i, sigb_i};
    sign_o    = a_big ? sa_i   : sb_i;
    exp_o     = a_big ? ea_i   : eb_i;
    e_small   = a_big ? eb_i   : ea_i;
    sig_big   = a_big ? siga_i : sigb_i;
    sig_small = a_big ? sigb_i : siga_i;
    diff      = exp_o - e_small;
    ext_s     = {sig_small, {GRS_W{1'b0}}};
    if (int'(diff) >= EXT_W) begin
      shifted = '0;
      sticky  = |sig_small;
    end else begin
      shifted = ext_s >> diff;
      sticky  = |(ext_s & ~({EXT_W{1'b1}} << diff));
    end
    big_o     = {sig_big, {GRS_W{1'b0}}};
    small_o   = shifted | {{(EXT_W-1){1'b0}}, sticky};
    eff_sub_o = sa_i ^ sb_i;
  end
endmodule

// File: rtl/fpa_round_pack.sv
module fpa_round_pack
  import fpa_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                  sign_i,
  input  logic [EXP_W-1:0]      exp_i,
  input  logic [FRAC_W+GRS_W:0] big_i,
  input  logic [FRAC_W+GRS_W:0] small_i,
  input  logic                  eff_sub_i,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  localparam int W       = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + GRS_W;
  localparam int SUM_W   = EXT_W + 1;
  localparam int EI_W    = EXP_W + 2;
  localparam int MANT_W  = SIG_W + 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  function automatic logic [EI_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic found;
    lead_zeros = '0;
    found      = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else      lead_zeros = lead_zeros + 1'b1;
      end
    end
  endfunction

  logic [SUM_W-1:0]  sum;
  logic [EXT_W-1:0]  norm;
  logic [EI_W-1:0]   lz;
  logic [EI_W-1:0]   e_n;
  logic [EI_W-1:0]   e_r;
  logic              rnd_up;
  logic [MANT_W-1:0] mant;

  always_comb begin
    sum = eff_sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                    : ({1'b0, big_i} + {1'b0, small_i});
    lz  = lead_zeros(sum[EXT_W-1:0]);
    if (sum[SUM_W-1]) begin
      // carry out: one step right, fold the lost bit into sticky
      norm = {sum[SUM_W-1:2], sum[1] | sum[0]};
      e_n  = {2'b00, exp_i} + EI_W'(1);
    end else begin
      norm = sum[EXT_W-1:0] << lz;
      e_n  = {2'b00, exp_i} - lz;
    end
    // nearest-even: guard set and (round | sticky | odd lsb)
    rnd_up = norm[GRS_W-1] & (norm[GRS_W-2] | (|norm[GRS_W-3:0]) | norm[GRS_W]);
    mant   = {1'b0, norm[EXT_W-1:GRS_W]} + MANT_W'(rnd_up);
    e_r    = mant[MANT_W-1] ? e_n + EI_W'(1) : e_n;

    ovf_o    = 1'b0;
    unf_o    = 1'b0;
    result_o = {sign_i, e_r[EXP_W-1:0], mant[FRAC_W-1:0]};
    if (sum == '0) begin
      result_o = '0;
    end else if (e_n[EI_W-1] || e_n == '0) begin
      unf_o    = 1'b1;
      result_o = {sign_i, {(W-1){1'b0}}};
    end else if (e_r >= EI_W'(EXP_MAX)) begin
      ovf_o    = 1'b1;
      result_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpa_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  op_sub,
  input  logic [EXP_W+FRAC_W:0] opnd_a,
  input  logic [EXP_W+FRAC_W:0] opnd_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flag_ovf,
  output logic                  flag_unf,
  output logic                  flag_inv
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + GRS_W;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  // ---------------- stage 0: unpack, classify, align ----------------
  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [SIG_W-1:0] siga, sigb;
  fp_class_t        ca, cb;

  fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .word_i(opnd_a), .flip_i(1'b0),
    .sign_o(sa), .exp_o(ea), .sig_o(siga), .cls_o(ca)
  );

  fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .word_i(opnd_b), .flip_i(op_sub),
    .sign_o(sb), .exp_o(eb), .sig_o(sigb), .cls_o(cb)
  );

  logic         spec_hit;
  logic         spec_inv;
  logic [W-1:0] spec_res;

  always_comb begin
    spec_hit = 1'b1;
    spec_inv = 1'b0;
    spec_res = '0;
    if (ca.is_nan | cb.is_nan | (ca.is_inf & cb.is_inf & (sa ^ sb))) begin
      spec_inv = 1'b1;
      spec_res = QNAN;
    end else if (ca.is_inf | cb.is_inf) begin
      spec_res = {ca.is_inf ? sa : sb, INF_MAG};
    end else if (ca.is_zero & cb.is_zero) begin
      spec_res = {sa & sb, {(W-1){1'b0}}};
    end else begin
      spec_hit = 1'b0;
    end
  end

  logic             al_sign;
  logic [EXP_W-1:0] al_exp;
  logic [EXT_W-1:0] al_big, al_small;
  logic             al_sub;

  fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sa_i(sa), .ea_i(ea), .siga_i(siga),
    .sb_i(sb), .eb_i(eb), .sigb_i(sigb),
    .sign_o(al_sign), .exp_o(al_exp),
    .big_o(al_big), .small_o(al_small), .eff_sub_o(al_sub)
  );

  // ---------------- stage 1 registers ----------------
  logic             s1_valid;
  logic             s1_special;
  logic             s1_spec_inv;
  logic [W-1:0]     s1_spec_res;
  logic             s1_sign;
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_small;
  logic             s1_sub;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_special  <= spec_hit;
      s1_spec_inv <= spec_inv;
      s1_spec_res <= spec_res;
      s1_sign     <= al_sign;
      s1_exp      <= al_exp;
      s1_big      <= al_big;
      s1_small    <= al_small;
      s1_sub      <= al_sub;
    end
  end

  // ---------------- stage 1: add, normalize, round ----------------
  logic [W-1:0] rp_res;
  logic         rp_ovf, rp_unf;

  fpa_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sign_i(s1_sign), .exp_i(s1_exp), .big_i(s1_big), .small_i(s1_small),
    .eff_sub_i(s1_sub), .result_o(rp_res), .ovf_o(rp_ovf), .unf_o(rp_unf)
  );

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inv  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        result   <= s1_special ? s1_spec_res : rp_res;
        flag_ovf <= ~s1_special & rp_ovf;
        flag_unf <= ~s1_special & rp_unf;
        flag_inv <= s1_special & s1_spec_inv;
      end
    end
  end

  // R12
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  // R13
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !flag_ovf && !flag_unf && !flag_inv));
  // R7
  ovf_inf_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_ovf) |-> (result[W-2:0] == INF_MAG));
  // R8
  unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_unf) |-> (result[W-2:0] == '0));
  // R10
  inv_qnan_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_inv) |-> (result == QNAN));
  // R10
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_ovf, flag_unf, flag_inv}));
  // R10
  no_stray_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !flag_inv) |-> !((&result[W-2:FRAC_W]) && (|result[FRAC_W-1:0])));
endmodule

// File: tb/fp_addsub_tb_top.sv
`timescale 1ns/1ps
module fp_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_ovf, flag_unf, flag_inv;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [31:0] QNAN = 32'h7FC00000;

  always #5 clk = ~clk;

  fp_addsub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
    .result(result), .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inv(flag_inv)
  );

  // flags packed as {out_valid, ovf, unf, inv}
  task automatic check(string req, logic [31:0] exp_res, logic [3:0] exp_fl);
    logic [3:0] got_fl;
    got_fl = {out_valid, flag_ovf, flag_unf, flag_inv};
    n_run++;
    if (result !== exp_res || got_fl !== exp_fl) begin
      n_fail++;
      $display("FAIL %s: result %h flags %b, expected %h flags %b",
               req, result, got_fl, exp_res, exp_fl);
    end
  endtask

  // ef = {ovf, unf, inv}; result sampled two edges after the input edge
  task automatic op(string req, logic [31:0] a, logic [31:0] b, logic s,
                    logic [31:0] er, logic [2:0] ef);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(req, er, {1'b1, ef});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R13 reset", 32'h0, 4'b0000);
  endtask

  task automatic t_add_basic();
    op("R1 1+2",     32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 3'b000);
    op("R1 neg add", 32'hBFC00000, 32'hBFC00000, 1'b0, 32'hC0400000, 3'b000);
  endtask

  task automatic t_sub_sign();
    op("R2 3-1", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 3'b000);
    op("R2 1-3", 32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 3'b000);
  endtask

  task automatic t_align_round();
    op("R3 tie even",  32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 3'b000);
    op("R3 tie odd",   32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 3'b000);
    op("R3 above tie", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 3'b000);
    op("R3 far shift", 32'h3F800000, 32'h00800000, 1'b0, 32'h3F800000, 3'b000);
  endtask

  task automatic t_carry();
    op("R4 1.5+1.5", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 3'b000);
    op("R4 1+1",     32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 3'b000);
  endtask

  task automatic t_cancel();
    op("R5 deep",    32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 3'b000);
    op("R5 shallow", 32'h3FC00000, 32'h3F800000, 1'b1, 32'h3F000000, 3'b000);
  endtask

  task automatic t_zero_sign();
    op("R6 x-x",   32'h40200000, 32'h40200000, 1'b1, 32'h00000000, 3'b000);
    op("R6 -x+x",  32'hC0200000, 32'h40200000, 1'b0, 32'h00000000, 3'b000);
    op("R6 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 3'b000);
    op("R6 -0-+0", 32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 3'b000);
    op("R6 +0+-0", 32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 3'b000);
  endtask

  task automatic t_overflow();
    op("R7 max+max",   32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 3'b100);
    op("R7 neg max",   32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 3'b100);
    op("R7 round ovf", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 3'b100);
  endtask

  task automatic t_underflow();
    op("R8 neg tiny", 32'h00800000, 32'h00800001, 1'b1, 32'h80000000, 3'b010);
    op("R8 pos tiny", 32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 3'b010);
  endtask

  task automatic t_denorm();
    op("R9 sub+1",   32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 3'b000);
    op("R9 sub+sub", 32'h007FFFFF, 32'h007FFFFF, 1'b0, 32'h00000000, 3'b000);
    op("R9 neg sub", 32'h807FFFFF, 32'h00000005, 1'b1, 32'h80000000, 3'b000);
  endtask

  task automatic t_nan();
    op("R10 nan a",     32'h7FC00001, 32'h3F800000, 1'b0, QNAN, 3'b001);
    op("R10 neg nan b", 32'h3F800000, 32'hFF800001, 1'b1, QNAN, 3'b001);
    op("R10 inf-inf",   32'h7F800000, 32'h7F800000, 1'b1, QNAN, 3'b001);
    op("R10 inf+-inf",  32'hFF800000, 32'h7F800000, 1'b0, QNAN, 3'b001);
    op("R10 inf+nan",   32'h7F800000, 32'h7F812345, 1'b0, QNAN, 3'b001);
  endtask

  task automatic t_inf();
    op("R11 inf+1",   32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 3'b000);
    op("R11 1-inf",   32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 3'b000);
    op("R11 inf+inf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 3'b000);
    op("R11 -inf-1",  32'hFF800000, 32'h3F800000, 1'b1, 32'hFF800000, 3'b000);
  endtask

  task automatic t_stream();
    @(negedge clk);
    opnd_a = 32'h3F800000; opnd_b = 32'h3F800000; op_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    opnd_a = 32'h40400000; opnd_b = 32'h3F800000; op_sub = 1'b1;
    @(negedge clk);
    opnd_a = 32'h7F800000; opnd_b = 32'h7F800000; op_sub = 1'b1;
    check("R12 stream 0", 32'h40000000, 4'b1000);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 stream 1", 32'h40000000, 4'b1000);
    @(negedge clk);
    check("R12 stream 2", QNAN, 4'b1001);
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 idle: out_valid %b, expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_add_basic();
    t_sub_sign();
    t_align_round();
    t_carry();
    t_cancel();
    t_zero_sign();
    t_overflow();
    t_underflow();
    t_denorm();
    t_nan();
    t_inf();
    t_stream();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run not complete, expected completion within 5000 cycles");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule